// File: doc/BRIEF.md
# Link Error Interrupt Aggregator

This block gathers six link error event lines into sticky status bits and turns them into one error interrupt and one fatal-error indicator. Each event arrives as a single-cycle pulse on its own input line and latches its status bit. The bit stays set until software acknowledges it. Detection of the errors themselves happens elsewhere.

Software reaches the block over a small 32-bit register port. Reads are combinational and writes take effect on the next clock edge. Software can read the raw latched status or the status filtered by the per-source enables. It changes the enables through separate set and clear registers, so it never needs a read-modify-write. It acknowledges an error by writing ones to the filtered-status register.

The interrupt output follows the enabled status. The fatal indicator covers a fixed pair of sources.

Top module: `err_irq_agg`

## Requirements
- R1: After reset the latched status and all enables are zero, `irq_o` and `fatal_o` are low, and every register reads zero.
- R2: The register map is: 0x1C0 raw status (read-only), 0x1C4 masked status (read; write-one-to-clear), 0x1C8 enable-set, and 0x1CC enable-clear. Both enable addresses read back the current enable vector in bits 5:0.
- R3: A one on `evt_i[n]` at a clock edge sets raw status bit n from that edge on, whatever the enable is. The bit stays set until it is acknowledged. The bit assignment is: 0 system, 1 fatal, 2 non-fatal, 3 correctable, 4 bus tag lookup fatal, 5 end-to-end CRC.
- R4: A write to 0x1C4 clears each raw bit whose data bit is 1 and leaves the others unchanged. A write to 0x1C0 changes nothing.
- R5: A write to 0x1C8 sets each enable whose data bit is 1, and a 0 data bit leaves its enable unchanged. Writing 0x3F enables every source.
- R6: A write to 0x1CC clears each enable whose data bit is 1, and a 0 data bit leaves its enable unchanged.
- R7: Masked status equals raw AND enable, and `irq_o` is high exactly when any masked bit is set.
- R8: `fatal_o` is high exactly when masked bit 1 or masked bit 4 is set. No other bit drives it.
- R9: When an event arrives in the same cycle as a write that clears its bit, the bit ends up set.
- R10: Bits 31:6 of every register read zero and ignore writes. Addresses outside the map read zero and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | 6 | Error event pulses, one per source |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 12 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid while `req_i` is high and `we_i` is low |
| irq_o | output | 1 | Error interrupt |
| fatal_o | output | 1 | Fatal-class error pending |

## Verification
The bench uses the default configuration: six sources, a 12-bit address and a 32-bit data path. With only six sources, every combination of enable vector and event pattern can be swept, which is 4096 pairs. Every pair checks the raw and masked reads, the enable readback and both outputs against arithmetic in the bench. A further 64-pattern sweep checks acknowledge masks against a full status. Separate cases cover a write to the read-only address, upper-bit writes, unmapped addresses and an event that collides with its own clear.

// File: rtl/err_irq_pkg.sv
package err_irq_pkg;
  localparam int unsigned NUM_SRC = 6;
  localparam logic [11:0] OFS_RAW    = 12'h1C0;
  localparam logic [11:0] OFS_MASKED = 12'h1C4;
  localparam logic [11:0] OFS_EN_SET = 12'h1C8;
  localparam logic [11:0] OFS_EN_CLR = 12'h1CC;
  // bits 1 (fatal) and 4 (bus tag lookup fatal)
  localparam logic [NUM_SRC-1:0] FATAL_CLASS = 6'b01_0010;
endpackage

// File: rtl/err_irq_bus.sv
module err_irq_bus #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_SRC  = err_irq_pkg::NUM_SRC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N_SRC-1:0]  raw_i,
  input  logic [N_SRC-1:0]  masked_i,
  input  logic [N_SRC-1:0]  en_i,
  output logic [N_SRC-1:0]  ack_o,
  output logic [N_SRC-1:0]  en_set_o,
  output logic [N_SRC-1:0]  en_clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  import err_irq_pkg::*;

  localparam int unsigned PAD_W = DATA_W - N_SRC;

  logic hit_raw, hit_msk, hit_set, hit_clr;
  logic wr, rd;
  logic [N_SRC-1:0] wbits;
  logic [N_SRC-1:0] rsel;

  assign hit_raw = (addr_i == ADDR_W'(OFS_RAW));
  assign hit_msk = (addr_i == ADDR_W'(OFS_MASKED));
  assign hit_set = (addr_i == ADDR_W'(OFS_EN_SET));
  assign hit_clr = (addr_i == ADDR_W'(OFS_EN_CLR));
  assign wr      = req_i & we_i;
  assign rd      = req_i & ~we_i;
  assign wbits   = wdata_i[N_SRC-1:0];

  assign ack_o    = (wr && hit_msk) ? wbits : '0;
  assign en_set_o = (wr && hit_set) ? wbits : '0;
  assign en_clr_o = (wr && hit_clr) ? wbits : '0;

  always_comb begin
    rsel = '0;
    if (rd) begin
      if (hit_raw)                rsel = raw_i;
      else if (hit_msk)           rsel = masked_i;
      else if (hit_set | hit_clr) rsel = en_i;
    end
  end

  assign rdata_o = {{PAD_W{1'b0}}, rsel};

  assert_upper_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:N_SRC] == '0);
  assert_idle_read_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |-> rdata_o == '0);
endmodule

// File: rtl/err_irq_state.sv
module err_irq_state #(
  parameter int unsigned N_SRC = err_irq_pkg::NUM_SRC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] evt_i,
  input  logic [N_SRC-1:0] ack_i,
  input  logic [N_SRC-1:0] en_set_i,
  input  logic [N_SRC-1:0] en_clr_i,
  output logic [N_SRC-1:0] raw_o,
  output logic [N_SRC-1:0] en_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic st_q, en_q;

    // event wins over a same-cycle acknowledge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         st_q <= 1'b0;
      else if (evt_i[i])   st_q <= 1'b1;
      else if (ack_i[i])   st_q <= 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           en_q <= 1'b0;
      else if (en_set_i[i])  en_q <= 1'b1;
      else if (en_clr_i[i])  en_q <= 1'b0;
    end

    assign raw_o[i] = st_q;
    assign en_o[i]  = en_q;

    assert_evt_latch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[i] |=> raw_o[i]);
    assert_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!evt_i[i] && !ack_i[i]) |=> $stable(raw_o[i]));
    assert_ack_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i[i] && !evt_i[i]) |=> !raw_o[i]);
    assert_en_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_set_i[i] |=> en_o[i]);
    assert_en_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_clr_i[i] && !en_set_i[i]) |=> !en_o[i]);
  end
endmodule

// File: rtl/err_irq_agg.sv
module err_irq_agg #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_SRC  = err_irq_pkg::NUM_SRC,
  parameter logic [N_SRC-1:0] FATAL_SEL = err_irq_pkg::FATAL_CLASS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  evt_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              fatal_o
);
  logic [N_SRC-1:0] raw, en, masked, ack, en_set, en_clr;

  err_irq_state #(.N_SRC(N_SRC)) u_state (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt_i),
    .ack_i    (ack),
    .en_set_i (en_set),
    .en_clr_i (en_clr),
    .raw_o    (raw),
    .en_o     (en)
  );

  err_irq_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_SRC(N_SRC)) u_bus (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .raw_i    (raw),
    .masked_i (masked),
    .en_i     (en),
    .ack_o    (ack),
    .en_set_o (en_set),
    .en_clr_o (en_clr),
    .rdata_o  (rdata_o)
  );

  assign masked  = raw & en;
  assign irq_o   = |masked;
  assign fatal_o = |(masked & FATAL_SEL);

  assert_irq_needs_en_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (en != '0));
  assert_irq_needs_raw_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (raw != '0));
  assert_fatal_implies_irq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |-> irq_o);
  assert_fatal_class_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |-> ((raw & FATAL_SEL) != '0));
  assert_collide_keeps_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((raw & $past(evt_i)) == $past(evt_i)));
endmodule

// File: tb/sim_err_irq_agg.sv
module sim_err_irq_agg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  evt = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fatal;
  int          n_vec = 0, n_err = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  err_irq_agg u0 (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fatal_o(fatal)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic pulse(input logic [5:0] p);
    @(negedge clk);
    evt = p;
    @(negedge clk);
    evt = '0;
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    if (!done) begin
      n_err++;
      n_vec++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [5:0]  m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 fatal", {31'b0, fatal}, 0);
    rd(12'h1C0, d); chk("R1 raw", d, 0);
    rd(12'h1C8, d); chk("R1 en", d, 0);

    // R3 R5 R7 R8: full sweep of enable x event pattern
    for (int e = 0; e < 64; e++) begin
      for (int p = 0; p < 64; p++) begin
        wr(12'h1CC, 32'h3F);
        wr(12'h1C8, 32'(e));
        wr(12'h1C4, 32'h3F);
        pulse(6'(p));
        m = 6'(p & e);
        rd(12'h1C0, d); chk("R3 raw", d, 32'(p));
        rd(12'h1C4, d); chk("R7 masked", d, 32'(m));
        rd(12'h1CC, d); chk("R5 enable", d, 32'(e));
        chk("R7 irq", {31'b0, irq}, {31'b0, m != 0});
        chk("R8 fatal", {31'b0, fatal}, {31'b0, (m & 6'h12) != 0});
      end
    end

    // R4: acknowledge masks against full status
    for (int w = 0; w < 64; w++) begin
      pulse(6'h3F);
      wr(12'h1C4, 32'(w));
      rd(12'h1C0, d); chk("R4 ack", d, 32'(6'h3F & ~6'(w)));
    end
    pulse(6'h3F);
    wr(12'h1C0, 32'h3F);
    rd(12'h1C0, d); chk("R4 raw write ignored", d, 32'h3F);

    // R6: partial enable clear
    wr(12'h1C8, 32'h3F);
    wr(12'h1CC, 32'h05);
    rd(12'h1C8, d); chk("R6 en clear", d, 32'h3A);

    // R9: event in same cycle as its ack
    wr(12'h1C4, 32'h3F);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 12'h1C4; wdata = 32'h3F; evt = 6'h10;
    @(negedge clk);
    req = 1'b0; we = 1'b0; wdata = '0; evt = '0;
    rd(12'h1C0, d); chk("R9 collide", d, 32'h10);
    chk("R9 fatal", {31'b0, fatal}, 1);

    // R10: upper bits and unmapped addresses
    wr(12'h1CC, 32'hFFFF_FFFF);
    wr(12'h1C8, 32'hFFFF_FFC0);
    rd(12'h1C8, d); chk("R10 upper set ignored", d, 0);
    wr(12'h1C8, 32'hFFFF_FFFF);
    rd(12'h1CC, d); chk("R10 upper read zero", d, 32'h3F);
    wr(12'h1D0, 32'h3F);
    rd(12'h1C0, d); chk("R10 unmapped write", d, 32'h10);
    rd(12'h1D0, d); chk("R10 unmapped read", d, 0);
    rd(12'h000, d); chk("R2 low addr read", d, 0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule